// File: doc/BRIEF.md
# SPI Slave Byte Transceiver with Double Buffering

This block receives and sends bytes as an SPI slave. The clock idles low, and each frame carries 8 bits with the most significant bit first. A CPU reaches it through a small register port. On the transmit side, a one-byte holding register feeds the transmit shift register. On the receive side, the receive shift register delivers each completed byte into a one-byte receive register. The holding register is copied into the shift register only when a frame starts. The start event depends on the phase control bit. With phase 0, the start is the falling edge of the slave select. With phase 1, the start is the first rising serial-clock edge while the slave is selected. A byte written while a frame is running waits in the holding register for the next start.

The serial clock, the slave select and the serial input must already be synchronous to `clk`. The block finds their edges by comparing each one with its value one cycle earlier. The serial output comes with its own output enable, and the pad buffer lies outside the block. Four status flags report receive full, overflow, transmit empty and mode fault. Each kind of flag can raise an interrupt line.

The register port is a valid/ready request channel. `bus_ready` is held high at all times, so every request is accepted in the cycle where `bus_valid` is high. A read returns `bus_rdata` in that same cycle, and its side effects take hold at the clock edge that ends the cycle. The serial side has no back-pressure. A byte that arrives while the receive register is still full is reported through the overflow flag.

Top module: `spi_slv`

## Requirements
- R1: After reset, the control register (address 0) reads 0x02, which is phase bit 1 set and enable bit 0 clear. The status register (address 1) reads 0x04, which is transmit-empty at bit 2. `miso_oe` is low.
- R2: While `ss_n` is high, `miso_oe` is low and serial-clock edges are ignored. No bit is counted and the receive-full flag is not set.
- R3: Phase 0 (control bit 1 clear) works as follows. The cycle after `ss_n` is seen falling, the holding byte is loaded and its MSB appears on `miso`, and transmit-empty (status bit 2) sets. `mosi` is sampled on rising edges and `miso` shifts on falling edges. The byte completes on the 8th rising edge.
- R4: Phase 1 works as follows. The first rising edge after select loads the holding byte and drives its MSB. Later rising edges shift, and falling edges sample. The byte completes on the 8th falling edge. Several bytes may follow each other in one select period.
- R5: A write to the data register (address 2) clears transmit-empty. If the write comes after a frame has started, that frame still sends the byte loaded at its start, and the written byte goes out in the next frame.
- R6: A completed byte is placed in the receive register, which is read at address 2, and receive-full (status bit 0) sets.
- R7: If a byte completes while receive-full is set, overflow (status bit 1) sets and the receive register keeps the older byte.
- R8: A status read followed directly by a data read clears receive-full and overflow. A data read without that preceding status read clears neither flag.
- R9: Mode fault (status bit 3) works as follows. If fault detection (control bit 5) is set and `ss_n` rises after a frame has started but before it has completed, the mode-fault flag sets and the partial byte is dropped. A status read followed directly by a control write clears the flag.
- R10: Clearing the enable bit aborts any frame and returns the engine to idle. After enable is set again, the next frame starts from its first bit.
- R11: The three interrupt lines are: `irq_tx` = transmit-empty AND control bit 2; `irq_rx` = receive-full AND control bit 4; `irq_err` = (overflow OR mode fault) AND control bit 3.
- R12: `bus_ready` is always high, and `bus_rdata` shows the addressed register in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Register request accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current request |
| sclk | input | 1 | Serial clock, synchronous to clk, idles low |
| ss_n | input | 1 | Slave select, active low |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for miso |
| irq_tx | output | 1 | Transmit-empty interrupt |
| irq_rx | output | 1 | Receive-full interrupt |
| irq_err | output | 1 | Overflow or mode-fault interrupt |

## Verification
Each serial edge takes effect one clock cycle after the bench changes the pin. A load, a shift, a sample, a completed byte and a flag update all show at the first rising edge of `clk` after the change. The bench therefore holds every serial level for two cycles and reads `miso` and the flags at the following falling edge. `miso_oe` and `bus_rdata` are combinational, so the bench samples them in the cycle of the stimulus, 1 ns after it drives them. Read and write side effects become visible from the next cycle on, and the bench reads status only after the request cycle has closed.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2
  } reg_sel_e;

  // Control fields, LSB first: enable, phase, tx irq, err irq, rx irq, fault detect
  typedef struct packed {
    logic mf_en;
    logic rx_ie;
    logic err_ie;
    logic tx_ie;
    logic cpha;
    logic enable;
  } ctrl_t;

  // Status fields, LSB first: rx full, overflow, tx empty, mode fault
  typedef struct packed {
    logic modf;
    logic tx_empty;
    logic ovf;
    logic rx_full;
  } stat_t;

  localparam ctrl_t CTRL_RESET = '{mf_en: 1'b0, rx_ie: 1'b0, err_ie: 1'b0,
                                   tx_ie: 1'b0, cpha: 1'b1, enable: 1'b0};
  localparam stat_t STAT_RESET = '{modf: 1'b0, tx_empty: 1'b1, ovf: 1'b0, rx_full: 1'b0};

endpackage

// File: rtl/spi_slv_edges.sv
module spi_slv_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic ss_n,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic ss_fall,
  output logic ss_rise
);
  logic sclk_q, ss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      ss_q   <= 1'b1;
    end else begin
      sclk_q <= sclk;
      ss_q   <= ss_n;
    end
  end

  assign sclk_rise = sclk & ~sclk_q;
  assign sclk_fall = ~sclk & sclk_q;
  assign ss_fall   = ~ss_n & ss_q;
  assign ss_rise   = ss_n & ~ss_q;
endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cpha,
  input  logic              ss_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              ss_fall,
  input  logic              ss_rise,
  input  logic              mosi,
  input  logic [DATA_W-1:0] tx_word,
  output logic              tx_load,
  output logic              byte_done,
  output logic              frame_abort,
  output logic [DATA_W-1:0] rx_word,
  output logic              busy,
  output logic              miso,
  output logic              miso_oe
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic [CNT_W-1:0]  cnt;
  logic              active, sample, shift;

  always_comb begin
    active      = enable & ~ss_n;
    tx_load     = cpha ? (active & sclk_rise & ~busy) : (enable & ss_fall);
    sample      = active & busy & (cpha ? sclk_fall : sclk_rise);
    shift       = active & busy & (cpha ? sclk_rise : sclk_fall);
    byte_done   = sample & (cnt == LAST_BIT);
    frame_abort = enable & ss_rise & busy;
    rx_word     = {rx_sh[DATA_W-2:0], mosi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
    end else if (!enable || ss_rise) begin
      // partial reset or deselect: back to idle, partial byte dropped
      tx_sh <= enable ? tx_sh : '0;
      rx_sh <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
    end else begin
      if (tx_load) begin
        tx_sh <= tx_word;
        cnt   <= '0;
        busy  <= 1'b1;
      end else if (shift) begin
        tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end
      if (sample) begin
        rx_sh <= rx_word;
        if (byte_done) begin
          cnt  <= '0;
          busy <= 1'b0;
        end else begin
          cnt <= cnt + ONE;
        end
      end
    end
  end

  assign miso    = tx_sh[DATA_W-1];
  assign miso_oe = active;
endmodule

// File: rtl/spi_slv_regs.sv
module spi_slv_regs
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tx_load,
  input  logic              byte_done,
  input  logic              frame_abort,
  input  logic [DATA_W-1:0] rx_word,
  output ctrl_t             ctrl,
  output stat_t             status,
  output logic [DATA_W-1:0] tx_word,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_err
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic [DATA_W-1:0] rx_data;
  logic              armed;
  logic              wr_ctrl, wr_data, rd_stat, rd_data;

  always_comb begin
    wr_ctrl = bus_valid &  bus_write & (bus_addr == REG_CTRL);
    wr_data = bus_valid &  bus_write & (bus_addr == REG_DATA);
    rd_stat = bus_valid & ~bus_write & (bus_addr == REG_STAT);
    rd_data = bus_valid & ~bus_write & (bus_addr == REG_DATA);
    case (bus_addr)
      REG_CTRL: bus_rdata = DATA_W'(ctrl);
      REG_STAT: bus_rdata = DATA_W'(status);
      REG_DATA: bus_rdata = rx_data;
      default:  bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= CTRL_RESET;
      status  <= STAT_RESET;
      tx_word <= '0;
      rx_data <= '0;
      armed   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_data) tx_word <= bus_wdata;

      if (rd_stat)        armed <= 1'b1;
      else if (bus_valid) armed <= 1'b0;

      // a write wins over a same-cycle load: the new byte was not taken
      if (wr_data)      status.tx_empty <= 1'b0;
      else if (tx_load) status.tx_empty <= 1'b1;

      if (byte_done) begin
        status.rx_full <= 1'b1;
        if (status.rx_full) status.ovf <= 1'b1;
        else                rx_data    <= rx_word;
      end else if (rd_data && armed) begin
        status.rx_full <= 1'b0;
        status.ovf     <= 1'b0;
      end

      if (frame_abort && ctrl.mf_en) status.modf <= 1'b1;
      else if (wr_ctrl && armed)     status.modf <= 1'b0;
    end
  end

  assign irq_tx  = status.tx_empty & ctrl.tx_ie;
  assign irq_rx  = status.rx_full & ctrl.rx_ie;
  assign irq_err = (status.ovf | status.modf) & ctrl.err_ie;
endmodule

// File: rtl/spi_slv.sv
module spi_slv
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sclk,
  input  logic              ss_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_err
);
  ctrl_t             ctrl;
  stat_t             status;
  logic [DATA_W-1:0] tx_word, rx_word;
  logic              sclk_rise, sclk_fall, ss_fall, ss_rise;
  logic              tx_load, byte_done, frame_abort, busy;

  assign bus_ready = 1'b1;

  spi_slv_edges i_edges (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .ss_fall(ss_fall), .ss_rise(ss_rise)
  );

  spi_slv_shift #(.DATA_W(DATA_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .enable(ctrl.enable), .cpha(ctrl.cpha),
    .ss_n(ss_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .ss_fall(ss_fall), .ss_rise(ss_rise), .mosi(mosi), .tx_word(tx_word),
    .tx_load(tx_load), .byte_done(byte_done), .frame_abort(frame_abort),
    .rx_word(rx_word), .busy(busy), .miso(miso), .miso_oe(miso_oe)
  );

  spi_slv_regs #(.DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_load(tx_load), .byte_done(byte_done), .frame_abort(frame_abort),
    .rx_word(rx_word), .ctrl(ctrl), .status(status), .tx_word(tx_word),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
  );
endmodule

// File: rtl/spi_slv_chk.sv
module spi_slv_chk
  import spi_slv_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ss_n,
  input logic       miso_oe,
  input logic       bus_valid,
  input logic       bus_write,
  input logic [1:0] bus_addr,
  input ctrl_t      ctrl,
  input stat_t      status,
  input logic       busy,
  input logic       tx_load,
  input logic       byte_done
);
  logic data_wr;
  assign data_wr = bus_valid & bus_write & (bus_addr == REG_DATA);

  AST_DESELECT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !miso_oe);                                                  // R2
  AST_WRITE_CLEARS_TXE: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !status.tx_empty);                                       // R5
  AST_LOAD_SETS_TXE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !data_wr) |=> status.tx_empty);                          // R3
  AST_BYTE_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> status.rx_full);                                       // R6
  AST_NO_OVERFLOW_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status.ovf) |-> $past(status.rx_full));                        // R7
  AST_FAULT_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status.modf) |-> ($past(ss_n) && $past(ctrl.mf_en)));          // R9
  AST_DISABLE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.enable |=> !busy);                                             // R10
endmodule

bind spi_slv spi_slv_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .miso_oe(miso_oe),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
  .ctrl(ctrl), .status(status), .busy(busy), .tx_load(tx_load),
  .byte_done(byte_done)
);

// File: tb/test_spi_slv.sv
module test_spi_slv;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       bus_ready;
  logic       sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic       miso, miso_oe, irq_tx, irq_rx, irq_err;
  int         checks = 0, failures = 0;
  bit         finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_slv i_spi_slv (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .irq_err(irq_err)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    tick(1);
    bus_valid = 1'b0;
  endtask

  // master side: n bits of mo, returns bits seen on miso
  task automatic spi_bits(input logic [7:0] mo, input logic cpha, input int n,
                          output logic [7:0] mi);
    mi = 8'h00;
    for (int i = 0; i < n; i++) begin
      if (!cpha) begin
        mosi = mo[7-i]; tick(1);
        mi[7-i] = miso;
        sclk = 1'b1; tick(2);
        sclk = 1'b0; tick(2);
      end else begin
        sclk = 1'b1; tick(2);
        mi[7-i] = miso; mosi = mo[7-i]; tick(1);
        sclk = 1'b0; tick(2);
      end
    end
  endtask

  task automatic frame0(input logic [7:0] mo, output logic [7:0] mi);
    ss_n = 1'b0; tick(2);
    spi_bits(mo, 1'b0, 8, mi);
    ss_n = 1'b1; tick(2);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    bus_rd(2'd0, d); check("R1 ctrl reset", d, 8'h02);
    bus_rd(2'd1, d); check("R1 status reset", d, 8'h04);
    check("R1 miso_oe reset", {7'd0, miso_oe}, 8'h00);
    check("R12 bus_ready", {7'd0, bus_ready}, 8'h01);
  endtask

  task automatic t_cpha0;
    logic [7:0] d, mi;
    bus_wr(2'd0, 8'h01);
    bus_wr(2'd2, 8'hA5);
    bus_rd(2'd1, d); check("R5 write clears tx empty", d, 8'h00);
    ss_n = 1'b0; #1;
    check("R3 oe on select", {7'd0, miso_oe}, 8'h01);
    tick(1);
    check("R3 MSB after select", {7'd0, miso}, 8'h01);
    bus_rd(2'd1, d); check("R3 tx empty on load", d, 8'h04);
    spi_bits(8'h3C, 1'b0, 8, mi);
    check("R3 miso byte", mi, 8'hA5);
    ss_n = 1'b1; tick(2);
    bus_rd(2'd1, d); check("R6 rx full", d, 8'h05);
    bus_rd(2'd2, d); check("R6 rx byte", d, 8'h3C);
    bus_rd(2'd1, d); check("R8 cleared", d, 8'h04);
  endtask

  task automatic t_midwrite;
    logic [7:0] d, mi;
    bus_wr(2'd0, 8'h01);
    bus_wr(2'd2, 8'h11);
    ss_n = 1'b0; tick(2);
    bus_wr(2'd2, 8'h22);
    spi_bits(8'h00, 1'b0, 8, mi);
    ss_n = 1'b1; tick(2);
    check("R5 frame keeps loaded byte", mi, 8'h11);
    bus_rd(2'd1, d); check("R5 tx empty stays clear", d & 8'h04, 8'h00);
    bus_rd(2'd2, d);
    frame0(8'h00, mi);
    check("R5 held byte next frame", mi, 8'h22);
    bus_rd(2'd1, d); bus_rd(2'd2, d);
  endtask

  task automatic t_cpha1;
    logic [7:0] d, mi;
    bus_wr(2'd0, 8'h03);
    bus_wr(2'd2, 8'hC3);
    ss_n = 1'b0; tick(2);
    bus_rd(2'd1, d); check("R4 no load before first edge", d, 8'h00);
    spi_bits(8'h5A, 1'b1, 8, mi);
    check("R4 first byte out", mi, 8'hC3);
    bus_rd(2'd1, d); check("R4 rx full", d, 8'h05);
    bus_rd(2'd2, d); check("R4 first byte in", d, 8'h5A);
    bus_wr(2'd2, 8'h96);
    spi_bits(8'h0F, 1'b1, 8, mi);
    check("R4 second byte out", mi, 8'h96);
    bus_rd(2'd1, d); bus_rd(2'd2, d);
    check("R4 second byte in", d, 8'h0F);
    ss_n = 1'b1; tick(2);
  endtask

  task automatic t_overflow;
    logic [7:0] d, mi;
    bus_wr(2'd0, 8'h01);
    frame0(8'hAA, mi);
    frame0(8'hBB, mi);
    bus_rd(2'd1, d); check("R7 overflow flag", d, 8'h07);
    bus_rd(2'd0, d);
    bus_rd(2'd2, d); check("R7 older byte kept", d, 8'hAA);
    bus_rd(2'd1, d); check("R8 no clear without status", d, 8'h07);
    bus_rd(2'd2, d);
    bus_rd(2'd1, d); check("R8 status then data clears", d, 8'h04);
  endtask

  task automatic t_deselect;
    logic [7:0] d, mi;
    bus_wr(2'd0, 8'h03);
    mosi = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
    end
    check("R2 oe low when deselected", {7'd0, miso_oe}, 8'h00);
    bus_rd(2'd1, d); check("R2 clocks ignored", d, 8'h04);
    bus_wr(2'd2, 8'h00);
    ss_n = 1'b0; tick(2);
    spi_bits(8'h6E, 1'b1, 8, mi);
    ss_n = 1'b1; tick(2);
    bus_rd(2'd1, d); bus_rd(2'd2, d);
    check("R2 frame aligned after ignored clocks", d, 8'h6E);
  endtask

  task automatic t_modf;
    logic [7:0] d, mi;
    bus_wr(2'd0, 8'h29);
    ss_n = 1'b0; tick(2);
    spi_bits(8'hF0, 1'b0, 3, mi);
    ss_n = 1'b1; tick(2);
    bus_rd(2'd1, d); check("R9 mode fault, no rx", d, 8'h0C);
    check("R11 irq_err", {7'd0, irq_err}, 8'h01);
    bus_wr(2'd0, 8'h29);
    bus_rd(2'd1, d); check("R9 fault cleared", d, 8'h04);
    check("R11 irq_err low", {7'd0, irq_err}, 8'h00);
    frame0(8'hE7, mi);
    bus_rd(2'd1, d); bus_rd(2'd2, d);
    check("R9 partial byte dropped", d, 8'hE7);
  endtask

  task automatic t_disable;
    logic [7:0] d, mi;
    bus_wr(2'd0, 8'h01);
    ss_n = 1'b0; tick(2);
    spi_bits(8'hFF, 1'b0, 3, mi);
    bus_wr(2'd0, 8'h00);
    check("R10 oe off when disabled", {7'd0, miso_oe}, 8'h00);
    bus_wr(2'd0, 8'h01);
    ss_n = 1'b1; tick(2);
    bus_rd(2'd1, d); check("R10 no byte from aborted frame", d & 8'h09, 8'h00);
    frame0(8'h81, mi);
    bus_rd(2'd1, d); bus_rd(2'd2, d);
    check("R10 restart from first bit", d, 8'h81);
  endtask

  task automatic t_irq;
    logic [7:0] d, mi;
    bus_wr(2'd0, 8'h15);
    check("R11 irq_tx on empty", {7'd0, irq_tx}, 8'h01);
    bus_wr(2'd2, 8'h3E);
    check("R11 irq_tx off after write", {7'd0, irq_tx}, 8'h00);
    check("R11 irq_rx idle", {7'd0, irq_rx}, 8'h00);
    frame0(8'h42, mi);
    check("R11 irq_tx after load", {7'd0, irq_tx}, 8'h01);
    check("R11 irq_rx on full", {7'd0, irq_rx}, 8'h01);
    bus_rd(2'd1, d); bus_rd(2'd2, d);
    check("R11 irq_rx cleared", {7'd0, irq_rx}, 8'h00);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_cpha0();
    t_midwrite();
    t_cpha1();
    t_overflow();
    t_deselect();
    t_modf();
    t_disable();
    t_irq();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule